// File: doc/BRIEF.md
# Line-Granular Memory-Mapped Request Decoder

This block sits between one memory-mapped master and a parameterised set of slave ports. All traffic moves in 128-bit lines with a 16-bit byte-enable. When the master starts a read or a write while the decoder is idle, the decoder samples the request once. It picks a slave by comparing the masked address against each slave's base value and drives that slave's strobe with a line index that is local to the slave. The selection then stays put until the chosen slave lowers its waitrequest.

A request that hits no slave, that is not aligned to a 16-byte line, or that asserts read and write together is not forwarded. Instead the decoder produces a one-cycle error with a reason code and pulses an abort line to every slave. It also drops waitrequest for that cycle so the master can finish the request. The slave-side interrupt is registered once and presented to the master.

Base and mask for each slave are parameter arrays. A configuration is only meaningful when every base has no bits outside its mask.

Top module: `line_bus_decoder`

## Requirements
- R1: While reset is applied and after it is released with no request, no slave is selected, no slave read or write strobe is high, `m_irq` and `m_err` are 0 and `m_waitreq` is 1.
- R2: An accepted request selects, one-hot on `s_sel`, the lowest-numbered slave i with (address AND MASK[i]) == BASE[i]. When several slaves match, the lower index wins.
- R3: `s_line` carries (address AND NOT MASK[i]) shifted right by 4. `s_wdata` and `s_be` carry the captured write data and byte enables.
- R4: A request is sampled only at a clock edge where the decoder is idle. While a slave is selected, changes on the master's address, data and byte-enable inputs have no effect on `s_sel`, `s_line` or `s_wdata`.
- R5: While a slave is selected, `m_waitreq` equals that slave's waitrequest and `m_rdata` equals that slave's read data. The selection is cleared at the first clock edge at which that waitrequest is low.
- R6: A request matching no slave gives, in the cycle after capture, `m_err`=1, `m_err_code`=2'b01, `s_abort`=1, `m_waitreq`=0 and no selection. `m_err` lasts exactly one cycle.
- R7: A request that matches a slave but has a nonzero address bit in [3:0] reports `m_err_code`=2'b10 in the same way. An unmatched address reports 2'b01 even when it is also misaligned.
- R8: A request with read and write both high reports `m_err_code`=2'b11, ahead of any address error. `s_read` and `s_write` are never high together.
- R9: `m_irq` equals the value `root_irq` had at the previous clock edge.
- R10: A slave strobe (`s_read` or `s_write` on the selected index) appears in the cycle after the edge that sampled the request. With neither read nor write high, nothing is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| m_addr | input | AW | Master byte address |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_wdata | input | LW | Master write line |
| m_be | input | LW/8 | Master byte enables |
| m_rdata | output | LW | Read line from the selected slave, zero when none |
| m_waitreq | output | 1 | Master waitrequest |
| m_err | output | 1 | One-cycle error pulse |
| m_err_code | output | 2 | 01 hole, 10 misaligned, 11 read and write together, 00 none |
| m_irq | output | 1 | Registered interrupt to the master |
| root_irq | input | 1 | Interrupt request from the root interrupt controller |
| s_sel | output | N_SLV | One-hot slave select |
| s_read | output | N_SLV | Per-slave read strobe |
| s_write | output | N_SLV | Per-slave write strobe |
| s_line | output | AW-4 | Line index inside the selected slave |
| s_wdata | output | LW | Captured write line |
| s_be | output | LW/8 | Captured byte enables |
| s_abort | output | 1 | Abort pulse to all slaves on an error |
| s_rdata | input | N_SLV*LW | Read lines, slave i at bits [i*LW +: LW] |
| s_waitreq | input | N_SLV | Per-slave waitrequest |

## Verification
The bench targets the overlap between slaves 1 and 2. A decoder without priority would raise two selects there or pick the wider window, and the line index would come out wrong. It also sends addresses that are both unmapped and misaligned, and requests with both operations, where the wrong error order would give the wrong code. While a slave stalls, it scrambles the master inputs. A design that re-sampled during a transaction would move `s_line` or `s_wdata` mid-flight. The bench then releases the slave after a random delay to catch a selection that drops early or late, or read data taken from a slave that is not selected.

// File: rtl/line_bus_pkg.sv
package line_bus_pkg;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'b00,
    ERR_HOLE   = 2'b01,
    ERR_ALIGN  = 2'b10,
    ERR_BOTHOP = 2'b11
  } err_code_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_BUSY  = 2'b01,
    ST_FAULT = 2'b10
  } lb_state_e;

endpackage

// File: rtl/line_bus_rst_sync.sv
module line_bus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/line_bus_match.sv
module line_bus_match #(
  parameter int N_SLV = 4,
  parameter int AW    = 32,
  parameter int OFS   = 4,
  parameter logic [N_SLV-1:0][AW-1:0] BASE = '0,
  parameter logic [N_SLV-1:0][AW-1:0] MASK = '0
) (
  input  logic [AW-1:0]     addr,
  output logic              hit,
  output logic [N_SLV-1:0]  sel_oh,
  output logic [AW-OFS-1:0] line
);

  logic [N_SLV-1:0] hit_vec;
  logic [N_SLV:0]   taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N_SLV; i++) begin : g_slot
    assign hit_vec[i]  = (addr & MASK[i]) == BASE[i];
    assign sel_oh[i]   = hit_vec[i] & ~taken[i];
    assign taken[i+1]  = taken[i] | hit_vec[i];
  end

  assign hit = taken[N_SLV];

  always_comb begin
    logic [AW-1:0] local_addr;
    local_addr = '0;
    for (int i = 0; i < N_SLV; i++) begin
      if (sel_oh[i]) local_addr = local_addr | ((addr & ~MASK[i]) >> OFS);
    end
    line = local_addr[AW-OFS-1:0];
  end

endmodule

// File: rtl/line_bus_rmux.sv
module line_bus_rmux #(
  parameter int N_SLV = 4,
  parameter int LW    = 128
) (
  input  logic [N_SLV-1:0]    sel,
  input  logic [N_SLV*LW-1:0] rdata_in,
  input  logic [N_SLV-1:0]    wait_in,
  output logic [LW-1:0]       rdata_out,
  output logic                wait_out
);

  always_comb begin
    rdata_out = '0;
    wait_out  = 1'b0;
    for (int i = 0; i < N_SLV; i++) begin
      rdata_out = rdata_out | ({LW{sel[i]}} & rdata_in[i*LW +: LW]);
      wait_out  = wait_out | (sel[i] & wait_in[i]);
    end
  end

endmodule

// File: rtl/line_bus_ctrl.sv
module line_bus_ctrl
  import line_bus_pkg::*;
#(
  parameter int N_SLV = 4,
  parameter int AW    = 32,
  parameter int LW    = 128,
  parameter int OFS   = 4,
  localparam int BEW  = LW / 8,
  localparam int LIW  = AW - OFS
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic             req_rd,
  input  logic             req_wr,
  input  logic             misaligned,
  input  logic [LW-1:0]    req_wdata,
  input  logic [BEW-1:0]   req_be,
  input  logic             hit,
  input  logic [N_SLV-1:0] sel_oh,
  input  logic [LIW-1:0]   line_in,
  input  logic             sel_wait,
  output logic             busy,
  output logic [N_SLV-1:0] sel_q,
  output logic             rd_q,
  output logic             wr_q,
  output logic [LIW-1:0]   line_q,
  output logic [LW-1:0]    wdata_q,
  output logic [BEW-1:0]   be_q,
  output logic             err_q,
  output logic [1:0]       code_q
);

  lb_state_e        state_q, state_d;
  err_code_e        code_d;
  logic             cap_en;
  logic [N_SLV-1:0] sel_d;

  always_comb begin
    state_d = state_q;
    code_d  = ERR_NONE;
    cap_en  = 1'b0;
    sel_d   = sel_q;
    case (state_q)
      ST_IDLE: begin
        if (req_rd || req_wr) begin
          if (req_rd && req_wr) begin
            state_d = ST_FAULT;
            code_d  = ERR_BOTHOP;
          end else if (!hit) begin
            state_d = ST_FAULT;
            code_d  = ERR_HOLE;
          end else if (misaligned) begin
            state_d = ST_FAULT;
            code_d  = ERR_ALIGN;
          end else begin
            state_d = ST_BUSY;
            cap_en  = 1'b1;
            sel_d   = sel_oh;
          end
        end
      end
      ST_BUSY: begin
        if (!sel_wait) begin
          state_d = ST_IDLE;
          sel_d   = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      err_q   <= 1'b0;
      code_q  <= ERR_NONE;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      err_q   <= (state_d == ST_FAULT);
      code_q  <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      line_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (cap_en) begin
      rd_q    <= req_rd;
      wr_q    <= req_wr;
      line_q  <= line_in;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  assign busy = (state_q == ST_BUSY);

endmodule

// File: rtl/line_bus_decoder.sv
module line_bus_decoder #(
  parameter int N_SLV = 4,
  parameter int AW    = 32,
  parameter int LW    = 128,
  parameter logic [N_SLV-1:0][AW-1:0] BASE =
    {32'h8000_0000, 32'h0001_0000, 32'h0001_0000, 32'h0000_0000},
  parameter logic [N_SLV-1:0][AW-1:0] MASK =
    {32'hC000_0000, 32'hFFFF_0000, 32'hFFFF_F000, 32'hFFFF_0000},
  localparam int BEW = LW / 8,
  localparam int OFS = $clog2(BEW),
  localparam int LIW = AW - OFS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       m_addr,
  input  logic                m_read,
  input  logic                m_write,
  input  logic [LW-1:0]       m_wdata,
  input  logic [BEW-1:0]      m_be,
  output logic [LW-1:0]       m_rdata,
  output logic                m_waitreq,
  output logic                m_err,
  output logic [1:0]          m_err_code,
  output logic                m_irq,
  input  logic                root_irq,
  output logic [N_SLV-1:0]    s_sel,
  output logic [N_SLV-1:0]    s_read,
  output logic [N_SLV-1:0]    s_write,
  output logic [LIW-1:0]      s_line,
  output logic [LW-1:0]       s_wdata,
  output logic [BEW-1:0]      s_be,
  output logic                s_abort,
  input  logic [N_SLV*LW-1:0] s_rdata,
  input  logic [N_SLV-1:0]    s_waitreq
);

  logic             rst_sync_n;
  logic             hit;
  logic [N_SLV-1:0] sel_oh;
  logic [LIW-1:0]   line_c;
  logic             sel_wait;
  logic             busy;
  logic [N_SLV-1:0] sel_q;
  logic             rd_q, wr_q;
  logic             err_q;
  logic [1:0]       code_q;
  logic             irq_q;

  line_bus_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  line_bus_match #(
    .N_SLV (N_SLV), .AW (AW), .OFS (OFS), .BASE (BASE), .MASK (MASK)
  ) i_match (
    .addr   (m_addr),
    .hit    (hit),
    .sel_oh (sel_oh),
    .line   (line_c)
  );

  line_bus_ctrl #(
    .N_SLV (N_SLV), .AW (AW), .LW (LW), .OFS (OFS)
  ) i_ctrl (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .req_rd     (m_read),
    .req_wr     (m_write),
    .misaligned (|m_addr[OFS-1:0]),
    .req_wdata  (m_wdata),
    .req_be     (m_be),
    .hit        (hit),
    .sel_oh     (sel_oh),
    .line_in    (line_c),
    .sel_wait   (sel_wait),
    .busy       (busy),
    .sel_q      (sel_q),
    .rd_q       (rd_q),
    .wr_q       (wr_q),
    .line_q     (s_line),
    .wdata_q    (s_wdata),
    .be_q       (s_be),
    .err_q      (err_q),
    .code_q     (code_q)
  );

  line_bus_rmux #(
    .N_SLV (N_SLV), .LW (LW)
  ) i_rmux (
    .sel       (sel_q),
    .rdata_in  (s_rdata),
    .wait_in   (s_waitreq),
    .rdata_out (m_rdata),
    .wait_out  (sel_wait)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= root_irq;
  end

  assign m_irq      = irq_q;
  assign s_sel      = sel_q;
  assign s_read     = {N_SLV{rd_q}} & sel_q;
  assign s_write    = {N_SLV{wr_q}} & sel_q;
  assign s_abort    = err_q;
  assign m_err      = err_q;
  assign m_err_code = code_q;
  assign m_waitreq  = err_q ? 1'b0 : (busy ? sel_wait : 1'b1);

endmodule

// File: rtl/line_bus_checker.sv
module line_bus_checker #(
  parameter int N_SLV = 4,
  parameter int LIW   = 28
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             root_irq,
  input logic             m_irq,
  input logic             m_err,
  input logic             m_waitreq,
  input logic             s_abort,
  input logic [N_SLV-1:0] s_sel,
  input logic [N_SLV-1:0] s_read,
  input logic [N_SLV-1:0] s_write,
  input logic [LIW-1:0]   s_line
);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(s_sel)); // R2

  AST_HOLD_SELECTION: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((|s_sel) && m_waitreq) |=> ($stable(s_sel) && $stable(s_line))); // R4

  AST_RELEASE_ON_READY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((|s_sel) && !m_waitreq) |=> (s_sel == '0)); // R5

  AST_ERR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    m_err |=> !m_err); // R6

  AST_ERR_RELEASES_MASTER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    m_err |-> (!m_waitreq && s_abort && (s_sel == '0))); // R6

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s_read & s_write) == '0); // R8

  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (m_irq == $past(root_irq))); // R9

  AST_STROBE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((s_read | s_write) & ~s_sel) == '0); // R10

endmodule

bind line_bus_decoder line_bus_checker #(.N_SLV(N_SLV), .LIW(LIW)) i_line_bus_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .root_irq   (root_irq),
  .m_irq      (m_irq),
  .m_err      (m_err),
  .m_waitreq  (m_waitreq),
  .s_abort    (s_abort),
  .s_sel      (s_sel),
  .s_read     (s_read),
  .s_write    (s_write),
  .s_line     (s_line)
);

// File: tb/test_line_bus_decoder.sv
`timescale 1ns/1ps
module test_line_bus_decoder;

  localparam int N   = 4;
  localparam int AW  = 32;
  localparam int LW  = 128;
  localparam int BEW = 16;
  localparam int LIW = 28;

  logic [31:0] tb_base [N] = '{32'h0000_0000, 32'h0001_0000, 32'h0001_0000, 32'h8000_0000};
  logic [31:0] tb_mask [N] = '{32'hFFFF_0000, 32'hFFFF_F000, 32'hFFFF_0000, 32'hC000_0000};

  logic            clk = 1'b0;
  logic            rst_n;
  logic [AW-1:0]   m_addr;
  logic            m_read, m_write;
  logic [LW-1:0]   m_wdata;
  logic [BEW-1:0]  m_be;
  logic [LW-1:0]   m_rdata;
  logic            m_waitreq, m_err, m_irq, root_irq;
  logic [1:0]      m_err_code;
  logic [N-1:0]    s_sel, s_read, s_write, s_waitreq;
  logic [LIW-1:0]  s_line;
  logic [LW-1:0]   s_wdata;
  logic [BEW-1:0]  s_be;
  logic            s_abort;
  logic [N*LW-1:0] s_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  line_bus_decoder i_line_bus_decoder (
    .clk (clk), .rst_n (rst_n),
    .m_addr (m_addr), .m_read (m_read), .m_write (m_write),
    .m_wdata (m_wdata), .m_be (m_be), .m_rdata (m_rdata),
    .m_waitreq (m_waitreq), .m_err (m_err), .m_err_code (m_err_code),
    .m_irq (m_irq), .root_irq (root_irq),
    .s_sel (s_sel), .s_read (s_read), .s_write (s_write),
    .s_line (s_line), .s_wdata (s_wdata), .s_be (s_be),
    .s_abort (s_abort), .s_rdata (s_rdata), .s_waitreq (s_waitreq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ref_slave(input logic [31:0] a);
    for (int i = 0; i < N; i++)
      if ((a & tb_mask[i]) == tb_base[i]) return i;
    return -1;
  endfunction

  function automatic logic [127:0] rnd_line();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic txn(input logic [31:0] a, input bit rd, input bit wr,
                     input logic [127:0] wd, input logic [15:0] be, input int delay);
    int k;
    logic [1:0] exp_code;
    logic [N-1:0] exp_sel;
    logic [27:0] exp_line;
    logic [127:0] rdv [N];
    logic [31:0] loc;
    @(negedge clk);
    m_addr = a; m_read = rd; m_write = wr; m_wdata = wd; m_be = be;
    s_waitreq = '1;
    k = ref_slave(a);
    if (rd && wr)          exp_code = 2'b11;
    else if (k < 0)        exp_code = 2'b01;
    else if (a[3:0] != 0)  exp_code = 2'b10;
    else                   exp_code = 2'b00;
    @(negedge clk);
    if (exp_code != 2'b00) begin
      chk(m_err == 1'b1, "R6", "error pulse", m_err, 1);
      chk(m_err_code == exp_code, exp_code == 2'b11 ? "R8" : (exp_code == 2'b10 ? "R7" : "R6"),
          "error code", m_err_code, exp_code);
      chk(m_waitreq == 1'b0 && s_abort == 1'b1 && s_sel == '0, "R6", "waitreq/abort/sel",
          {m_waitreq, s_abort, s_sel}, {1'b0, 1'b1, 4'b0});
      m_read = 0; m_write = 0;
      @(negedge clk);
      chk(m_err == 1'b0 && m_waitreq == 1'b1, "R6", "error one cycle", {m_err, m_waitreq}, 2'b01);
    end else begin
      exp_sel = N'(1) << k;
      loc = (a & ~tb_mask[k]) >> 4;
      exp_line = loc[27:0];
      chk(s_sel == exp_sel, "R2", "select", s_sel, exp_sel);
      chk(s_read == (rd ? exp_sel : '0) && s_write == (wr ? exp_sel : '0), "R10", "strobes",
          {s_read, s_write}, {(rd ? exp_sel : 4'b0), (wr ? exp_sel : 4'b0)});
      chk(s_line == exp_line, "R3", "line index", s_line, exp_line);
      chk(s_wdata == wd && s_be == be, "R3", "wdata/be", s_wdata, wd);
      chk(m_waitreq == 1'b1, "R5", "waitreq follows slave", m_waitreq, 1);
      m_addr = ~a; m_wdata = ~wd; m_be = ~be;
      for (int d = 0; d < delay; d++) begin
        @(negedge clk);
        chk(s_sel == exp_sel && s_line == exp_line && s_wdata == wd, "R4", "held while stalled",
            s_line, exp_line);
      end
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        rdv[i] = rnd_line();
        s_rdata[i*LW +: LW] = rdv[i];
      end
      s_waitreq[k] = 1'b0;
      #1;
      chk(m_waitreq == 1'b0, "R5", "waitreq released", m_waitreq, 0);
      chk(m_rdata == rdv[k], "R5", "read data mux", m_rdata, rdv[k]);
      @(negedge clk);
      m_read = 0; m_write = 0; s_waitreq = '1;
      chk(s_sel == '0 && s_read == '0 && s_write == '0, "R5", "selection cleared", s_sel, 0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 0; m_addr = '0; m_read = 0; m_write = 0; m_wdata = '0; m_be = '0;
    root_irq = 1; s_waitreq = '1; s_rdata = '0;
    repeat (3) @(negedge clk);
    chk(m_irq == 0 && s_sel == '0 && m_err == 0, "R1", "state in reset", {m_irq, s_sel, m_err}, 0);
    rst_n = 1; root_irq = 0;
    repeat (4) @(negedge clk);
    chk(s_sel == '0 && s_read == '0 && s_write == '0 && m_irq == 0 && m_err == 0 && m_waitreq == 1,
        "R1", "state after reset", {s_sel, s_read, s_write, m_irq, m_err, m_waitreq}, 1);
    repeat (3) @(negedge clk);
    chk(s_sel == '0, "R10", "no request no select", s_sel, 0);

    for (int i = 0; i < 6; i++) begin
      logic v;
      v = 1'($urandom);
      root_irq = v;
      @(negedge clk);
      chk(m_irq == v, "R9", "irq registered", m_irq, v);
    end
    root_irq = 0;

    txn(32'h0001_0040, 1, 0, rnd_line(), 16'hFFFF, 2);   // overlap: slave 1 wins (R2)
    txn(32'h0001_2000, 0, 1, rnd_line(), 16'h00F0, 0);   // slave 2 only
    txn(32'hBFFF_FFF0, 1, 0, rnd_line(), 16'hFFFF, 3);   // slave 3 top line
    txn(32'h0000_0000, 0, 1, rnd_line(), 16'h0001, 1);   // slave 0 first line
    txn(32'h0002_0004, 1, 0, rnd_line(), 16'hFFFF, 0);   // hole and misaligned: hole (R7)
    txn(32'h0000_0008, 1, 0, rnd_line(), 16'hFFFF, 0);   // misaligned (R7)
    txn(32'h0000_0010, 1, 1, rnd_line(), 16'hFFFF, 0);   // both ops (R8)
    txn(32'h4000_0000, 0, 1, rnd_line(), 16'hFFFF, 0);   // hole (R6)

    for (int n = 0; n < 80; n++) begin
      logic [31:0] picks [6] = '{32'h0000_0000, 32'h0001_0000, 32'h0001_8000,
                                 32'h8000_0000, 32'h0002_0000, 32'hC000_0000};
      logic [31:0] a;
      int op;
      a = picks[$urandom % 6] | ($urandom & 32'h0000_0FF0);
      if (($urandom % 8) == 0) a[3:0] = 4'($urandom | 1);
      op = $urandom % 10;
      txn(a, op < 5 || op == 9, op >= 5, rnd_line(), 16'($urandom), $urandom % 4);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule